// File: doc/BRIEF.md
# Configurable Port LUT Fabric

This block is a small logic fabric that sits in the signal path of one 8-lane I/O port, between the pins and the on-chip peripherals. It holds eight three-input look-up tables. A configuration-driven routing matrix picks each table input from three places: the pin inputs, the peripheral outputs, or the previous-cycle results of the tables. Glue logic such as gating, inversion, or XOR-ing two PWM signals can then be built on inbound or outbound signals with no CPU involvement.

Each lane has its own bypass bit and direction bit. A bypassed lane passes both directions straight through. An active lane replaces either its outbound signal (toward the pin) or its inbound signal (toward the peripheral) with its table result. A sticky wake flag is raised when an interrupt-enabled table result changes, so a sleeping core can be woken by port activity. Software clears the flag through the configuration port.

All outputs are registered, with one clock of latency from inputs to outputs.

Top module: `plf_port_fabric`

## Requirements
- R1: Synchronous active-high reset clears pin_out, periph_in and wake to 0. Reset sets every lane to bypass, zeroes every truth table and every input select, clears all direction bits and clears all interrupt-enable bits.
- R2: For a lane whose bypass bit is 1, pin_out[k] equals periph_out[k] and periph_in[k] equals pin_in[k], one clock after the inputs are presented.
- R3: A table result equals bit {in2,in1,in0} of that lane's 8-bit truth table, where in0 is the least significant index bit. The result is purely combinational from the selected sources and is registered once at the outputs.
- R4: Each table input has a 5-bit select code, decoded as follows:
  - codes 0-7 choose pin_in[code];
  - codes 8-15 choose periph_out[code-8];
  - codes 16-23 choose the registered (previous-cycle) result of table code-16;
  - codes 24-31 choose constant 0.
- R5: For a lane that is not bypassed, the direction bit sets the lane's routing:
  - direction 0: pin_out[k] carries the table result and periph_in[k] carries pin_in[k];
  - direction 1: periph_in[k] carries the table result and pin_out[k] carries periph_out[k].
- R6: wake goes to 1 on the same clock edge on which any registered table result with its interrupt-enable bit set changes value. It then stays 1 until cleared.
- R7: A write to the clear address drops wake to 0 on the next edge, unless an enabled result changes in that same cycle, in which case setting wins. Changes of results whose enable bit is 0 never set wake.
- R8: The configuration map is as follows. Writes to any other address (36-63) change nothing.
  - address k (0-7): truth table of lane k;
  - address 8+3k+j: select for input j of lane k, in data bits 4:0;
  - address 32: bypass mask;
  - address 33: direction mask;
  - address 34: interrupt-enable mask;
  - address 35: wake clear (the data value is ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pin_in | input | 8 | Signals arriving from the port pins |
| periph_out | input | 8 | Signals leaving the peripherals toward the port |
| pin_out | output | 8 | Registered signals driven to the port pins |
| periph_in | output | 8 | Registered signals delivered to the peripherals |
| wake | output | 1 | Sticky wake/interrupt flag |

## Verification
The hardest situation to reach from the ports is a wake-clear write that lands in the same cycle as an enabled table result changing. The bench first routes a peripheral XOR into an interrupt-enabled lane. It then flips a peripheral input at the same falling edge on which the clear write is presented, so both reach one rising edge together. Feedback selects are reached by chaining one table to another table's registered result. The bench then checks both cycles of the resulting one-clock lag at the pin.

// File: rtl/plf_pkg.sv
package plf_pkg;

  typedef enum logic [1:0] {
    SRC_PIN,
    SRC_PERIPH,
    SRC_FEEDBACK,
    SRC_ZERO
  } src_grp_e;

  // Decode which source group a select code falls in.
  function automatic src_grp_e src_group(input logic [31:0] code, input int unsigned lanes);
    if (code < 32'(lanes))        return SRC_PIN;
    else if (code < 32'(2*lanes)) return SRC_PERIPH;
    else if (code < 32'(3*lanes)) return SRC_FEEDBACK;
    else                          return SRC_ZERO;
  endfunction

  // Base code of a source group.
  function automatic logic [31:0] group_base(input src_grp_e g, input int unsigned lanes);
    case (g)
      SRC_PERIPH:   return 32'(lanes);
      SRC_FEEDBACK: return 32'(2*lanes);
      default:      return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/plf_cfg_regs.sv
module plf_cfg_regs #(
  parameter int LANES  = 8,
  parameter int LUT_IN = 3,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cfg_we,
  input  logic [ADDR_W-1:0]                     cfg_addr,
  input  logic [DATA_W-1:0]                     cfg_wdata,
  output logic [LANES-1:0][(1<<LUT_IN)-1:0]     tt_q,
  output logic [LANES*LUT_IN-1:0][SEL_W-1:0]    sel_q,
  output logic [LANES-1:0]                      byp_q,
  output logic [LANES-1:0]                      dir_q,
  output logic [LANES-1:0]                      ien_q,
  output logic                                  wake_clr
);

  localparam int TT_W     = 1 << LUT_IN;
  localparam int NSEL     = LANES * LUT_IN;
  localparam int SEL_BASE = LANES;
  localparam int BYP_ADDR = SEL_BASE + NSEL;
  localparam int DIR_ADDR = BYP_ADDR + 1;
  localparam int IEN_ADDR = BYP_ADDR + 2;
  localparam int CLR_ADDR = BYP_ADDR + 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      tt_q  <= '0;
      sel_q <= '0;
      byp_q <= '1;
      dir_q <= '0;
      ien_q <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < LANES; k++) begin
        if (cfg_addr == ADDR_W'(k)) tt_q[k] <= cfg_wdata[TT_W-1:0];
      end
      for (int s = 0; s < NSEL; s++) begin
        if (cfg_addr == ADDR_W'(SEL_BASE + s)) sel_q[s] <= cfg_wdata[SEL_W-1:0];
      end
      if (cfg_addr == ADDR_W'(BYP_ADDR)) byp_q <= cfg_wdata[LANES-1:0];
      if (cfg_addr == ADDR_W'(DIR_ADDR)) dir_q <= cfg_wdata[LANES-1:0];
      if (cfg_addr == ADDR_W'(IEN_ADDR)) ien_q <= cfg_wdata[LANES-1:0];
    end
  end

  assign wake_clr = cfg_we && (cfg_addr == ADDR_W'(CLR_ADDR));

endmodule

// File: rtl/plf_lut_cell.sv
module plf_lut_cell #(
  parameter int LANES  = 8,
  parameter int LUT_IN = 3,
  parameter int SEL_W  = 5
) (
  input  logic [LANES-1:0]               pin_in,
  input  logic [LANES-1:0]               periph_out,
  input  logic [LANES-1:0]               fb,
  input  logic [LUT_IN-1:0][SEL_W-1:0]   sel,
  input  logic [(1<<LUT_IN)-1:0]         tt,
  output logic                           y
);

  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LUT_IN-1:0] idx;

  for (genvar j = 0; j < LUT_IN; j++) begin : g_in
    logic [31:0]        code;
    plf_pkg::src_grp_e  grp;
    logic [LW-1:0]      off;
    logic               b;

    assign code = 32'(sel[j]);
    assign grp  = plf_pkg::src_group(code, LANES);
    assign off  = LW'(code - plf_pkg::group_base(grp, LANES));

    always_comb begin
      case (grp)
        plf_pkg::SRC_PIN:      b = pin_in[off];
        plf_pkg::SRC_PERIPH:   b = periph_out[off];
        plf_pkg::SRC_FEEDBACK: b = fb[off];
        default:               b = 1'b0;
      endcase
    end

    assign idx[j] = b;
  end

  assign y = tt[idx];

endmodule

// File: rtl/plf_wake.sv
module plf_wake #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lut_d,
  input  logic [LANES-1:0] lut_q,
  input  logic [LANES-1:0] ien,
  input  logic             clr,
  output logic             wake
);

  logic hit;

  assign hit = |((lut_d ^ lut_q) & ien);

  always_ff @(posedge clk) begin
    if (rst)      wake <= 1'b0;
    else if (hit) wake <= 1'b1;
    else if (clr) wake <= 1'b0;
  end

endmodule

// File: rtl/plf_port_fabric.sv
module plf_port_fabric #(
  parameter int LANES  = 8,
  parameter int LUT_IN = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [LANES-1:0]  pin_in,
  input  logic [LANES-1:0]  periph_out,
  output logic [LANES-1:0]  pin_out,
  output logic [LANES-1:0]  periph_in,
  output logic              wake
);

  localparam int TT_W  = 1 << LUT_IN;
  localparam int SRC_N = 3 * LANES;
  localparam int SEL_W = $clog2(SRC_N + 1);
  localparam int NSEL  = LANES * LUT_IN;

  logic [LANES-1:0][TT_W-1:0]  tt_q;
  logic [NSEL-1:0][SEL_W-1:0]  sel_q;
  logic [LANES-1:0]            byp_q, dir_q, ien_q;
  logic                        wake_clr;
  logic [LANES-1:0]            lut_d, lut_q;
  logic [LANES-1:0]            pin_nx, per_nx;

  plf_cfg_regs #(
    .LANES(LANES), .LUT_IN(LUT_IN), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tt_q(tt_q), .sel_q(sel_q), .byp_q(byp_q), .dir_q(dir_q), .ien_q(ien_q),
    .wake_clr(wake_clr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    plf_lut_cell #(.LANES(LANES), .LUT_IN(LUT_IN), .SEL_W(SEL_W)) u_cell (
      .pin_in(pin_in),
      .periph_out(periph_out),
      .fb(lut_q),
      .sel(sel_q[k*LUT_IN +: LUT_IN]),
      .tt(tt_q[k]),
      .y(lut_d[k])
    );

    always_comb begin
      if (byp_q[k]) begin
        pin_nx[k] = periph_out[k];
        per_nx[k] = pin_in[k];
      end else if (dir_q[k]) begin
        pin_nx[k] = periph_out[k];
        per_nx[k] = lut_d[k];
      end else begin
        pin_nx[k] = lut_d[k];
        per_nx[k] = pin_in[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_q     <= '0;
      pin_out   <= '0;
      periph_in <= '0;
    end else begin
      lut_q     <= lut_d;
      pin_out   <= pin_nx;
      periph_in <= per_nx;
    end
  end

  plf_wake #(.LANES(LANES)) u_wake (
    .clk(clk), .rst(rst), .lut_d(lut_d), .lut_q(lut_q), .ien(ien_q),
    .clr(wake_clr), .wake(wake)
  );

endmodule

// File: rtl/plf_port_fabric_chk.sv
module plf_port_fabric_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] pin_in,
  input logic [LANES-1:0] periph_out,
  input logic [LANES-1:0] pin_out,
  input logic [LANES-1:0] periph_in,
  input logic             wake,
  input logic [LANES-1:0] byp_q,
  input logic [LANES-1:0] dir_q,
  input logic [LANES-1:0] ien_q,
  input logic             wake_clr,
  input logic [LANES-1:0] lut_d,
  input logic [LANES-1:0] lut_q
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && periph_in == '0 && !wake && lut_q == '0)); // R1

  AST_BYPASS_OUTBOUND: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pin_out ^ $past(periph_out)) & $past(byp_q)) == '0)); // R2

  AST_BYPASS_INBOUND: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((periph_in ^ $past(pin_in)) & $past(byp_q)) == '0)); // R2

  AST_DIR_PIN_SIDE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((periph_in ^ $past(pin_in)) & ~$past(byp_q) & ~$past(dir_q)) == '0)); // R5

  AST_DIR_PERIPH_SIDE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pin_out ^ $past(periph_out)) & ~$past(byp_q) & $past(dir_q)) == '0)); // R5

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> (((lut_q ^ $past(lut_q)) & $past(ien_q)) != '0)); // R6

  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wake && !wake_clr) |=> wake); // R6

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wake_clr && (((lut_d ^ lut_q) & ien_q) == '0)) |=> !wake); // R7

endmodule

bind plf_port_fabric plf_port_fabric_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .pin_in(pin_in), .periph_out(periph_out),
  .pin_out(pin_out), .periph_in(periph_in), .wake(wake),
  .byp_q(byp_q), .dir_q(dir_q), .ien_q(ien_q), .wake_clr(wake_clr),
  .lut_d(lut_d), .lut_q(lut_q)
);

// File: tb/plf_port_fabric_test.sv
`timescale 1ns/1ps
module plf_port_fabric_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] periph_out = '0;
  logic [7:0] pin_out, periph_in;
  logic       wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [5:0] A_BYP = 6'd32;
  localparam logic [5:0] A_DIR = 6'd33;
  localparam logic [5:0] A_IEN = 6'd34;
  localparam logic [5:0] A_CLR = 6'd35;

  // {pin_in, periph_out, expected pin_out, expected periph_in}
  localparam logic [31:0] VEC [0:5] = '{
    32'h00_00_00_00,
    32'h07_00_01_05,
    32'h03_01_00_03,
    32'hFF_F3_F3_FD,
    32'h5A_A5_A4_5A,
    32'h04_02_02_06
  };

  always #2.5 clk = ~clk;

  plf_port_fabric uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pin_in(pin_in), .periph_out(periph_out), .pin_out(pin_out),
    .periph_in(periph_in), .wake(wake)
  );

  task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cfg_write(input logic [5:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [7:0] p, input logic [7:0] q);
    pin_in = p; periph_out = q;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    pin_in = 8'hA5; periph_out = 8'h3C;
    repeat (3) @(negedge clk);
    check("R1 reset pin_out", pin_out, 8'h00);
    check("R1 reset periph_in", periph_in, 8'h00);
    check("R1 reset wake", {7'd0, wake}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R2 default bypass pin_out", pin_out, 8'h3C);
    check("R2 default bypass periph_in", periph_in, 8'hA5);

    // R1: truth tables start at zero
    cfg_write(A_BYP, 8'hFE);
    drive(8'hFF, 8'hFF);
    check("R1 zero truth table lane0", pin_out, 8'hFE);
    check("R1 zero truth table periph_in", periph_in, 8'hFF);

    // Lane0: AND of pins 0..2 toward pin; lane1: periph0 ^ periph1 toward peripheral (R8 map)
    cfg_write(6'd0, 8'h80);
    cfg_write(6'd8, 8'd0);  cfg_write(6'd9, 8'd1);  cfg_write(6'd10, 8'd2);
    cfg_write(6'd1, 8'h66);
    cfg_write(6'd11, 8'd8); cfg_write(6'd12, 8'd9); cfg_write(6'd13, 8'd24);
    cfg_write(A_DIR, 8'h02);
    cfg_write(A_BYP, 8'hFC);
    foreach (VEC[i]) begin
      drive(VEC[i][31:24], VEC[i][23:16]);
      check($sformatf("R3 R5 vector %0d pin_out", i), pin_out, VEC[i][15:8]);
      check($sformatf("R3 R5 vector %0d periph_in", i), periph_in, VEC[i][7:0]);
    end

    // R4: constant-zero codes give index 0
    cfg_write(6'd2, 8'h01);
    cfg_write(6'd14, 8'd25); cfg_write(6'd15, 8'd30); cfg_write(6'd16, 8'd31);
    cfg_write(A_BYP, 8'hF8);
    drive(8'hFF, 8'h00);
    check("R4 zero codes with pins high", pin_out, 8'h05);
    drive(8'h00, 8'h00);
    check("R4 zero codes with pins low", pin_out, 8'h04);

    // R3: input 0 is the index LSB
    cfg_write(6'd3, 8'h02);
    cfg_write(6'd17, 8'd3); cfg_write(6'd18, 8'd4); cfg_write(6'd19, 8'd5);
    cfg_write(A_BYP, 8'hF0);
    drive(8'h08, 8'h00);
    check("R3 index 1 selected", pin_out, 8'h0C);
    drive(8'h10, 8'h00);
    check("R3 index 2 not selected", pin_out, 8'h04);
    drive(8'h20, 8'h00);
    check("R3 index 4 not selected", pin_out, 8'h04);

    // R4: feedback code 16 follows lane0 one clock later
    cfg_write(6'd4, 8'hAA);
    cfg_write(6'd20, 8'd16); cfg_write(6'd21, 8'd24); cfg_write(6'd22, 8'd24);
    cfg_write(A_BYP, 8'hE0);
    drive(8'h07, 8'h00);
    check("R4 feedback first cycle", pin_out, 8'h05);
    drive(8'h07, 8'h00);
    check("R4 feedback second cycle", pin_out, 8'h15);

    // R8: unmapped address is ignored
    cfg_write(6'd40, 8'h00);
    drive(8'h07, 8'hE0);
    check("R8 unmapped write ignored", pin_out, 8'hF5);

    // R6/R7: wake on lane1 only
    cfg_write(A_IEN, 8'h02);
    check("R6 no change no wake", {7'd0, wake}, 8'h00);
    drive(8'h00, 8'hE0);
    drive(8'h00, 8'hE0);
    check("R7 disabled lanes do not wake", {7'd0, wake}, 8'h00);
    drive(8'h00, 8'hE1);
    check("R6 enabled change raises wake", {7'd0, wake}, 8'h01);
    drive(8'h00, 8'hE1);
    check("R6 wake holds", {7'd0, wake}, 8'h01);
    drive(8'h00, 8'hE0);
    check("R6 wake holds after second change", {7'd0, wake}, 8'h01);
    cfg_write(A_CLR, 8'h5A);
    check("R7 clear drops wake", {7'd0, wake}, 8'h00);
    periph_out = 8'hE1;
    cfg_write(A_CLR, 8'h00);
    check("R7 set wins over clear", {7'd0, wake}, 8'h01);
    cfg_write(A_CLR, 8'h00);
    check("R7 second clear", {7'd0, wake}, 8'h00);

    finish_run();
  end

endmodule